// File: doc/BRIEF.md
# Serial Fuse Word Programming Sequencer

This block burns one 32-bit word of a one-time-programmable fuse array. On a start request it latches the word address, the requested data and four timing counts. It then reads the word already stored at that address and clears every request bit whose fuse is already blown, so no fuse is ever driven twice. The remaining pattern is shifted right with zero fill, one bit position per step. Each step that presents a 1 at the low end raises a program strobe for that bit, with relax padding before and after the strobe.

After the last bit position the block waits for a read-recovery gap and then for a quiet period. Only then does it give a one-cycle done pulse and become ready again. The fuse array is reached through a word-read port and a per-bit program port. Register decoding and bus access are handled elsewhere.

Top module: `fuse_prog_seq`

## Requirements
- R1: While reset is low and after it is released with no start, `busy_o`, `done_o`, `fuse_rd_en_o` and `fuse_pgm_en_o` are 0.
- R2: A start is accepted when `start_i` is 1 and `busy_o` is 0. Address, data and timing inputs are captured in that cycle. Later changes to them, and any start while busy, have no effect on the operation.
- R3: After acceptance the block waits `relax_i`+1 cycles. It then holds `fuse_rd_en_o` high for max(`read_i`,1) cycles with `fuse_addr_o` equal to the captured address, and samples `fuse_rd_data_i` on the last of those cycles.
- R4: Strobes are issued only for bit positions that are 1 in the captured data and 0 in the word read. They are issued in ascending bit order, and `fuse_pgm_bit_o` gives the bit index (bit 0 is the LSB).
- R5: Each program strobe holds `fuse_pgm_en_o` high for max(`strobe_i`,1) cycles, with `fuse_addr_o` equal to the captured address.
- R6: With L = `relax_i`+1, the number of low cycles between the end of the read and the first strobe, at bit j, is j+1+L. Between strobes at bits i<j it is 2L+(j-i). A relax count of 0 is valid.
- R7: After the last bit position, a gap of max(`read_i`,1) cycles and then a quiet period of max(`quiet_i`,1) cycles elapse. Then `done_o` is high for exactly one cycle, during which `busy_o` is 0. With last strobe at bit i, the low cycles before done number L+(31-i)+max(read,1)+max(quiet,1).
- R8: A start present in the done cycle is accepted, so operations can run back to back.
- R9: If the masked pattern is all zero, no strobe is issued. The low cycles between the end of the read and done number 32+max(read,1)+max(quiet,1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request to program one word |
| addr_i | input | ADDR_W | Fuse word address |
| data_i | input | DATA_W | Bits to blow (1 = blow) |
| relax_i | input | RLX_W | Relax count; padding phases last this value plus one |
| strobe_i | input | CNT_W | Program strobe width in cycles |
| read_i | input | RD_W | Read strobe width and post-burn read gap in cycles |
| quiet_i | input | CNT_W | Quiet period in cycles after the write |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fuse_addr_o | output | ADDR_W | Word address to the fuse array |
| fuse_rd_en_o | output | 1 | Fuse word read strobe |
| fuse_rd_data_i | input | DATA_W | Word read from the fuse array |
| fuse_pgm_en_o | output | 1 | Fuse program strobe |
| fuse_pgm_bit_o | output | IDX_W | Index of the bit being blown |

## Verification
The done pulse of one operation and the acceptance of the next start can fall in the same cycle. The bench provokes this by keeping start high from the first operation onward while it changes address, data and timings to those of the second operation. The scoreboard then expects exactly one read sequence, with the first operation's values, before the first done. It expects the second read to begin `relax_i`+1 low cycles after that done cycle, and it compares the burned words in the array model against both requests.

// File: rtl/fuse_seq_pkg.sv
`timescale 1ns/1ps
// Shared types for the fuse programming sequencer.
package fuse_seq_pkg;
    // Phases of one programming operation.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_PRE,
        ST_RD_STB,
        ST_BIT,
        ST_PRE,
        ST_STB,
        ST_POST,
        ST_GAP,
        ST_QUIET,
        ST_DONE
    } seq_state_t;
endpackage

// File: rtl/fuse_seq_timer.sv
`timescale 1ns/1ps
// Phase timer: a down counter loaded with (phase length - 1).
// It reports zero during the final cycle of a phase.
// Assumes the controller reloads it on every phase change.
module fuse_seq_timer #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    assign zero = (cnt == '0);

    // Load on phase entry, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (load)  cnt <= load_val;
        else if (!zero) cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/fuse_seq_shifter.sv
`timescale 1ns/1ps
// Program pattern register: captures the request, masks out bits
// already blown, then shifts right with zero fill while tracking the
// index of the bit now at the low end.
// Assumes at most one of capture, apply_mask, shift is active per cycle.
module fuse_seq_shifter #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] cap_data,
    input  logic              apply_mask,
    input  logic [DATA_W-1:0] fuse_word,
    input  logic              shift,
    output logic              lsb,
    output logic [IDX_W-1:0]  idx,
    output logic              last
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

    logic [DATA_W-1:0] pat;
    logic [DATA_W-1:0] masked;

    // Per-bit mask: keep a request bit only if its fuse is still intact.
    for (genvar b = 0; b < DATA_W; b++) begin : g_mask
        assign masked[b] = pat[b] & ~fuse_word[b];
    end

    assign lsb  = pat[0];
    assign last = (idx == LAST_IDX);

    // Pattern register update: capture, mask, or zero-fill shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pat <= '0;
            idx <= '0;
        end else if (capture) begin
            pat <= cap_data;
            idx <= '0;
        end else if (apply_mask) begin
            pat <= masked;
        end else if (shift) begin
            pat <= {1'b0, pat[DATA_W-1:1]};
            idx <= idx + 1'b1;
        end
    end
endmodule

// File: rtl/fuse_seq_ctrl.sv
`timescale 1ns/1ps
// Sequencing controller: owns the phase state, latches the timing
// counts at acceptance and drives timer loads and pattern operations.
// Assumes the timer and shifter respond on the next clock edge.
module fuse_seq_ctrl
    import fuse_seq_pkg::*;
#(
    parameter int RLX_W = 4,
    parameter int CNT_W = 12,
    parameter int RD_W  = 6,
    parameter int TMR_W = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [RLX_W-1:0] relax,
    input  logic [CNT_W-1:0] strobe,
    input  logic [RD_W-1:0]  rd_cnt,
    input  logic [CNT_W-1:0] quiet,
    input  logic             tmr_zero,
    input  logic             lsb,
    input  logic             last,
    output logic             tmr_load,
    output logic [TMR_W-1:0] tmr_val,
    output logic             capture,
    output logic             apply_mask,
    output logic             shift,
    output logic             busy,
    output logic             done,
    output logic             rd_en,
    output logic             pgm_en
);
    seq_state_t st, nxt;

    logic [TMR_W-1:0] rlx_ext, stb_ext, rd_ext, qt_ext;
    logic [TMR_W-1:0] rlx_q, stb_m1_q, rd_m1_q, qt_m1_q;

    assign rlx_ext = {{(TMR_W-RLX_W){1'b0}}, relax};
    assign stb_ext = {{(TMR_W-CNT_W){1'b0}}, strobe};
    assign rd_ext  = {{(TMR_W-RD_W){1'b0}},  rd_cnt};
    assign qt_ext  = {{(TMR_W-CNT_W){1'b0}}, quiet};

    assign busy   = (st != ST_IDLE) && (st != ST_DONE);
    assign done   = (st == ST_DONE);
    assign rd_en  = (st == ST_RD_STB);
    assign pgm_en = (st == ST_STB);

    // Latch timing counts as (length - 1), zero lengths raised to one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rlx_q    <= '0;
            stb_m1_q <= '0;
            rd_m1_q  <= '0;
            qt_m1_q  <= '0;
        end else if (capture) begin
            rlx_q    <= rlx_ext;
            stb_m1_q <= (stb_ext == '0) ? '0 : stb_ext - 1'b1;
            rd_m1_q  <= (rd_ext  == '0) ? '0 : rd_ext  - 1'b1;
            qt_m1_q  <= (qt_ext  == '0) ? '0 : qt_ext  - 1'b1;
        end
    end

    // Phase state register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // Next phase and the side actions taken on each phase change.
    always_comb begin
        nxt        = st;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        capture    = 1'b0;
        apply_mask = 1'b0;
        shift      = 1'b0;
        case (st)
            ST_IDLE, ST_DONE: begin
                nxt = ST_IDLE;
                if (start) begin
                    nxt      = ST_RD_PRE;
                    capture  = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = rlx_ext;
                end
            end
            ST_RD_PRE: begin
                if (tmr_zero) begin
                    nxt      = ST_RD_STB;
                    tmr_load = 1'b1;
                    tmr_val  = rd_m1_q;
                end
            end
            ST_RD_STB: begin
                if (tmr_zero) begin
                    nxt        = ST_BIT;
                    apply_mask = 1'b1;
                end
            end
            ST_BIT: begin
                if (lsb) begin
                    nxt      = ST_PRE;
                    tmr_load = 1'b1;
                    tmr_val  = rlx_q;
                end else begin
                    shift = 1'b1;
                    if (last) begin
                        nxt      = ST_GAP;
                        tmr_load = 1'b1;
                        tmr_val  = rd_m1_q;
                    end
                end
            end
            ST_PRE: begin
                if (tmr_zero) begin
                    nxt      = ST_STB;
                    tmr_load = 1'b1;
                    tmr_val  = stb_m1_q;
                end
            end
            ST_STB: begin
                if (tmr_zero) begin
                    nxt      = ST_POST;
                    tmr_load = 1'b1;
                    tmr_val  = rlx_q;
                end
            end
            ST_POST: begin
                if (tmr_zero) begin
                    shift = 1'b1;
                    if (last) begin
                        nxt      = ST_GAP;
                        tmr_load = 1'b1;
                        tmr_val  = rd_m1_q;
                    end else begin
                        nxt = ST_BIT;
                    end
                end
            end
            ST_GAP: begin
                if (tmr_zero) begin
                    nxt      = ST_QUIET;
                    tmr_load = 1'b1;
                    tmr_val  = qt_m1_q;
                end
            end
            ST_QUIET: begin
                if (tmr_zero) nxt = ST_DONE;
            end
            default: nxt = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/fuse_prog_seq.sv
`timescale 1ns/1ps
// Serial fuse word programming sequencer (top).
// Reads the target word, masks the request with it, then blows the
// remaining bits one at a time with relax-padded strobes, and closes
// with a read gap and a quiet period before a one-cycle done pulse.
// Assumes a fuse array with a combinational word read and a per-bit
// program input; requires CNT_W >= RD_W and CNT_W >= RLX_W.
module fuse_prog_seq #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 7,
    parameter int RLX_W  = 4,
    parameter int CNT_W  = 12,
    parameter int RD_W   = 6,
    parameter int IDX_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [RLX_W-1:0]  relax_i,
    input  logic [CNT_W-1:0]  strobe_i,
    input  logic [RD_W-1:0]   read_i,
    input  logic [CNT_W-1:0]  quiet_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [ADDR_W-1:0] fuse_addr_o,
    output logic              fuse_rd_en_o,
    input  logic [DATA_W-1:0] fuse_rd_data_i,
    output logic              fuse_pgm_en_o,
    output logic [IDX_W-1:0]  fuse_pgm_bit_o
);
    localparam int TMR_W = CNT_W + 1;

    logic             tmr_load, tmr_zero;
    logic [TMR_W-1:0] tmr_val;
    logic             capture, apply_mask, shift;
    logic             lsb, last;
    logic [ADDR_W-1:0] addr_q;

    // Word address held constant for the whole operation.
    always_ff @(posedge clk) begin
        if (!rst_n)       addr_q <= '0;
        else if (capture) addr_q <= addr_i;
    end

    assign fuse_addr_o = addr_q;

    fuse_seq_ctrl #(
        .RLX_W(RLX_W), .CNT_W(CNT_W), .RD_W(RD_W), .TMR_W(TMR_W)
    ) ctrl_i (
        .clk(clk), .rst_n(rst_n), .start(start_i),
        .relax(relax_i), .strobe(strobe_i), .rd_cnt(read_i), .quiet(quiet_i),
        .tmr_zero(tmr_zero), .lsb(lsb), .last(last),
        .tmr_load(tmr_load), .tmr_val(tmr_val),
        .capture(capture), .apply_mask(apply_mask), .shift(shift),
        .busy(busy_o), .done(done_o),
        .rd_en(fuse_rd_en_o), .pgm_en(fuse_pgm_en_o)
    );

    fuse_seq_timer #(.W(TMR_W)) timer_i (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
        .zero(tmr_zero)
    );

    fuse_seq_shifter #(.DATA_W(DATA_W), .IDX_W(IDX_W)) shifter_i (
        .clk(clk), .rst_n(rst_n),
        .capture(capture), .cap_data(data_i),
        .apply_mask(apply_mask), .fuse_word(fuse_rd_data_i),
        .shift(shift), .lsb(lsb), .idx(fuse_pgm_bit_o), .last(last)
    );
endmodule

// File: rtl/fuse_prog_seq_chk.sv
`timescale 1ns/1ps
// Protocol checker for the fuse programming sequencer, bound to the top.
// Keeps its own copies of the strobe, read and quiet lengths taken at
// acceptance and measures strobe widths and idle runs with counters.
module fuse_prog_seq_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 7,
    parameter int CNT_W  = 12,
    parameter int RD_W   = 6,
    parameter int IDX_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [CNT_W-1:0]  strobe_i,
    input logic [RD_W-1:0]   read_i,
    input logic [CNT_W-1:0]  quiet_i,
    input logic              busy_o,
    input logic              done_o,
    input logic [ADDR_W-1:0] fuse_addr_o,
    input logic              fuse_rd_en_o,
    input logic [DATA_W-1:0] fuse_rd_data_i,
    input logic              fuse_pgm_en_o,
    input logic [IDX_W-1:0]  fuse_pgm_bit_o
);
    localparam int LW = CNT_W + 3;

    logic [LW-1:0] stb_len, rd_len, qt_len, pgm_run, idle_run;

    // Lengths expected for the operation being accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_len <= LW'(1);
            rd_len  <= LW'(1);
            qt_len  <= LW'(1);
        end else if (start_i && !busy_o) begin
            stb_len <= (strobe_i == '0) ? LW'(1) : LW'(strobe_i);
            rd_len  <= (read_i   == '0) ? LW'(1) : LW'(read_i);
            qt_len  <= (quiet_i  == '0) ? LW'(1) : LW'(quiet_i);
        end
    end

    // Width of the current strobe and length of the current idle run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pgm_run  <= '0;
            idle_run <= '0;
        end else begin
            pgm_run  <= fuse_pgm_en_o ? pgm_run + 1'b1 : '0;
            if (fuse_pgm_en_o || fuse_rd_en_o) idle_run <= '0;
            else if (idle_run != '1)           idle_run <= idle_run + 1'b1;
        end
    end

    // R5: every strobe lasts the captured strobe length.
    a_r5_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fuse_pgm_en_o) |-> (pgm_run == stb_len));

    // R5: program strobes only inside an operation, never with a read.
    a_r5_pgm_in_op: assert property (@(posedge clk) disable iff (!rst_n)
        fuse_pgm_en_o |-> (busy_o && !fuse_rd_en_o));

    // R4: a strobe never starts on a fuse that already reads as blown.
    a_r4_no_reblow: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fuse_pgm_en_o) |-> !fuse_rd_data_i[fuse_pgm_bit_o]);

    // R2: the word address does not move during an operation.
    a_r2_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(fuse_addr_o));

    // R7: done is a single-cycle pulse outside busy.
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7: read gap and quiet period precede done.
    a_r7_quiet_before_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && idle_run >= rd_len + qt_len));
endmodule

bind fuse_prog_seq fuse_prog_seq_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .RD_W(RD_W), .IDX_W(IDX_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .strobe_i(strobe_i), .read_i(read_i), .quiet_i(quiet_i),
    .busy_o(busy_o), .done_o(done_o), .fuse_addr_o(fuse_addr_o),
    .fuse_rd_en_o(fuse_rd_en_o), .fuse_rd_data_i(fuse_rd_data_i),
    .fuse_pgm_en_o(fuse_pgm_en_o), .fuse_pgm_bit_o(fuse_pgm_bit_o)
);

// File: tb/fuse_prog_seq_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected read, strobe and done
// events; a monitor at the falling edge measures and compares them.
module fuse_prog_seq_tb_top;
    localparam int DW = 32, AW = 7, RW = 4, CW = 12, DRW = 6, IW = 5;
    localparam int K_READ = 0, K_STB = 1, K_DONE = 2;

    typedef struct {
        int kind;
        int bitn;
        int width;
        int gap;
        int addr;
        string tag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [DW-1:0] data_i = '0;
    logic [RW-1:0] relax_i = '0;
    logic [CW-1:0] strobe_i = '0;
    logic [DRW-1:0] read_i = '0;
    logic [CW-1:0] quiet_i = '0;
    logic          busy_o, done_o, fuse_rd_en_o, fuse_pgm_en_o;
    logic [AW-1:0] fuse_addr_o;
    logic [DW-1:0] fuse_rd_data_i;
    logic [IW-1:0] fuse_pgm_bit_o;

    logic [DW-1:0] fmem [0:(1<<AW)-1];
    logic          pl_req = 1'b0;
    logic [AW-1:0] pl_addr = '0;
    logic [DW-1:0] pl_val = '0;

    int checks = 0, fails = 0;
    bit finished = 1'b0;
    item_t exq[$];

    always #2.5 clk = ~clk;

    fuse_prog_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
        .data_i(data_i), .relax_i(relax_i), .strobe_i(strobe_i),
        .read_i(read_i), .quiet_i(quiet_i), .busy_o(busy_o), .done_o(done_o),
        .fuse_addr_o(fuse_addr_o), .fuse_rd_en_o(fuse_rd_en_o),
        .fuse_rd_data_i(fuse_rd_data_i), .fuse_pgm_en_o(fuse_pgm_en_o),
        .fuse_pgm_bit_o(fuse_pgm_bit_o)
    );

    // Fuse array model: combinational word read, bits blown on strobe.
    assign fuse_rd_data_i = fmem[fuse_addr_o];
    always @(posedge clk) begin
        if (pl_req) fmem[pl_addr] <= pl_val;
        if (fuse_pgm_en_o) fmem[fuse_addr_o][fuse_pgm_bit_o] <= 1'b1;
    end

    task automatic check(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic preload(int a, logic [DW-1:0] v);
        @(posedge clk); #1;
        pl_req = 1'b1; pl_addr = AW'(a); pl_val = v;
        @(posedge clk); #1;
        pl_req = 1'b0;
    endtask

    // Driver: expected events of one operation from the requirements.
    task automatic expect_op(int a, logic [DW-1:0] d, int rlx, int stb, int rd, int qt);
        logic [DW-1:0] m;
        item_t it;
        int lr, ls, lrd, lq, prev;
        m   = d & ~fmem[a];
        lr  = rlx + 1;
        ls  = (stb == 0) ? 1 : stb;
        lrd = (rd == 0) ? 1 : rd;
        lq  = (qt == 0) ? 1 : qt;
        it = '{K_READ, 0, lrd, lr, a, "R3"};
        exq.push_back(it);
        prev = -1;
        for (int b = 0; b < DW; b++) begin
            if (m[b]) begin
                it = '{K_STB, b, ls, (prev < 0) ? (b + 1 + lr) : (2 * lr + b - prev), a, "R6"};
                exq.push_back(it);
                prev = b;
            end
        end
        if (prev < 0) it = '{K_DONE, 0, 0, 32 + lrd + lq, a, "R9"};
        else          it = '{K_DONE, 0, 0, lr + (31 - prev) + lrd + lq, a, "R7"};
        exq.push_back(it);
    endtask

    task automatic set_in(int a, logic [DW-1:0] d, int rlx, int stb, int rd, int qt);
        addr_i = AW'(a); data_i = d; relax_i = RW'(rlx);
        strobe_i = CW'(stb); read_i = DRW'(rd); quiet_i = CW'(qt);
    endtask

    task automatic launch();
        @(posedge clk); #1 start_i = 1'b1;
        @(posedge clk); #1 start_i = 1'b0;
    endtask

    task automatic wait_done();
        do @(negedge clk); while (!done_o);
        @(posedge clk); #1;
    endtask

    // Monitor: measure widths and low-cycle gaps, compare with the queue.
    int run = 0, width = 0, gcap = 0, bcap = 0, acap = 0, kcap = 0;
    bit prev_act = 1'b0;
    always @(negedge clk) begin
        item_t e;
        if (rst_n && !finished) begin
            if (fuse_rd_en_o || fuse_pgm_en_o) begin
                if (!prev_act) begin
                    gcap = run; width = 0; bcap = int'(fuse_pgm_bit_o);
                    acap = int'(fuse_addr_o); kcap = fuse_rd_en_o ? K_READ : K_STB;
                end
                width++;
                prev_act = 1'b1;
            end else begin
                if (prev_act) begin
                    if (exq.size() == 0) begin
                        check(1'b0, "R2", "unexpected strobe kind", kcap, -1);
                    end else begin
                        e = exq.pop_front();
                        check(kcap == e.kind, "R4", "event kind", kcap, e.kind);
                        check(acap == e.addr, "R2", "strobe address", acap, e.addr);
                        if (e.kind == K_STB) begin
                            check(bcap == e.bitn, "R4", "blown bit index", bcap, e.bitn);
                            check(width == e.width, "R5", "strobe width", width, e.width);
                            check(gcap == e.gap, "R6", "gap before strobe", gcap, e.gap);
                        end else begin
                            check(width == e.width, "R3", "read width", width, e.width);
                            check(gcap == e.gap, "R3", "relax before read", gcap, e.gap);
                        end
                    end
                    run = 0;
                end
                prev_act = 1'b0;
                if (done_o) begin
                    if (exq.size() == 0) begin
                        check(1'b0, "R7", "unexpected done", run, -1);
                    end else begin
                        e = exq.pop_front();
                        check(e.kind == K_DONE, "R7", "done order kind", K_DONE, e.kind);
                        check(gcap >= 0 && run == e.gap, e.tag, "low cycles before done", run, e.gap);
                        check(!busy_o, "R7", "busy during done", busy_o, 0);
                    end
                end
                run++;
            end
            if (start_i && !busy_o) run = 0;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: outputs quiet in and right after reset.
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!busy_o && !done_o && !fuse_rd_en_o && !fuse_pgm_en_o, "R1",
              "outputs in reset", {busy_o, done_o, fuse_rd_en_o, fuse_pgm_en_o}, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!busy_o && !done_o && !fuse_rd_en_o && !fuse_pgm_en_o, "R1",
              "outputs after reset", {busy_o, done_o, fuse_rd_en_o, fuse_pgm_en_o}, 0);

        // R8 and R2: start held high; second request staged while busy.
        preload(5, 32'h0);
        preload(9, 32'h0000_00F0);
        expect_op(5, 32'h8000_0001, 2, 5, 3, 10);
        expect_op(9, 32'h0000_0FF3, 0, 0, 0, 0);
        @(posedge clk); #1;
        set_in(5, 32'h8000_0001, 2, 5, 3, 10);
        start_i = 1'b1;
        @(posedge clk); #1;
        set_in(9, 32'h0000_0FF3, 0, 0, 0, 0);
        do @(negedge clk); while (!done_o);
        @(posedge clk); #1 start_i = 1'b0;
        wait_done();
        check(fmem[5] == 32'h8000_0001, "R2", "word 5 after burn", int'(fmem[5]), 32'h8000_0001);
        check(fmem[9] == 32'h0000_0FF3, "R4", "word 9 after masked burn", int'(fmem[9]), 32'h0000_0FF3);

        // R9: every requested bit already blown.
        preload(12, 32'hA5A5_A5A5);
        expect_op(12, 32'h0000_A5A5, 1, 3, 2, 4);
        set_in(12, 32'h0000_A5A5, 1, 3, 2, 4);
        launch();
        wait_done();
        check(fmem[12] == 32'hA5A5_A5A5, "R9", "word 12 unchanged", int'(fmem[12]), int'(32'hA5A5_A5A5));

        // R2 and R5: all bits at the top address, stray start mid-run.
        preload(127, 32'h0);
        preload(3, 32'h0);
        expect_op(127, 32'hFFFF_FFFF, 1, 2, 1, 3);
        set_in(127, 32'hFFFF_FFFF, 1, 2, 1, 3);
        launch();
        repeat (20) @(posedge clk);
        #1 set_in(3, 32'h0000_FFFF, 0, 7, 0, 0);
        start_i = 1'b1;
        @(posedge clk); #1 start_i = 1'b0;
        wait_done();
        check(fmem[127] == 32'hFFFF_FFFF, "R4", "word 127 fully blown", int'(fmem[127]), -1);
        check(fmem[3] == 32'h0, "R2", "start while busy ignored", int'(fmem[3]), 0);

        // R9: zero request leaves the word alone.
        preload(64, 32'h0000_1234);
        expect_op(64, 32'h0, 3, 4, 5, 6);
        set_in(64, 32'h0, 3, 4, 5, 6);
        launch();
        wait_done();
        check(fmem[64] == 32'h0000_1234, "R9", "word 64 unchanged", int'(fmem[64]), 32'h0000_1234);

        repeat (10) @(posedge clk);
        check(exq.size() == 0, "R2", "events left in scoreboard", exq.size(), 0);
        check(!busy_o && !done_o, "R7", "idle after last op", {busy_o, done_o}, 0);
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule